// File: doc/BRIEF.md
# Cascadable Serial Configuration Readout Controller

This block is the read side of a serial configuration store that feeds a programmable-logic device one bit per configuration clock. It walks a word address counter and a bit counter across an address range, asks a synchronous memory for one word at a time, and presents the word's bits most-significant first on a single data line that has its own drive enable. A combined control line does two jobs. Held low it rewinds the counters and releases the data line. Held high it enables output. An active-low select gates counting, so a high select freezes the counters and puts the block in standby.

The range can be the whole address space, or one of four equal quarters chosen by a 2-bit page code. The range inputs are captured only on a rewind. When the last bit of the range has been sent, the block releases the data line and pulls its cascade output low, so a second device whose select is wired to that output takes over the line. A serial-enable input, when low, hands the memory to a programming path and silences the read side. A power-on counter holds the ready flag low for a fixed number of clocks after the asynchronous power-on reset.

The memory port has a fixed latency of one cycle and no back-pressure. An address presented with the read enable high returns its word on the next clock. The data line has no handshake: a bit is valid in every cycle in which the drive enable is high.

Top module: `cfg_stream_reader`

## Requirements
- R1: `ready` is low from power-on reset until `POR_CYCLES` rising clock edges after `por_n` is released, then high for good. Before `ready` rises nothing counts, `data_oe` stays low and `casc_n` stays high.
- R2: With `rst_oe` low, `data_oe` is low in that same cycle whatever `cs_n` is. At the next edge the bit counter goes to zero, the word address goes to the base of the range given by the page inputs, and the end-of-range state is cleared.
- R3: The counters advance only on edges where `cs_n` is low, `rst_oe` is high, `ser_en` has been high for at least one edge and `ready` is high. With `cs_n` high the counters hold and `data_oe` is low.
- R4: Bit k of a word (k = 0 is the first bit) is `mem_rd_data[WORD_W-1-k]`. Successive words follow with no idle cycle. `mem_rd_addr` always carries the address whose word is needed in the next cycle, and `data_out` is 0 whenever `data_oe` is low.
- R5: With `page_en` = 1 at a rewind, `page_sel` selects quarter q of the address space, from q·2^(ADDR_W-2) to (q+1)·2^(ADDR_W-2)-1. Code 00 is the lowest quarter and 11 the highest.
- R6: With `page_en` = 0 at a rewind, `page_sel` is ignored and the range is 0 to 2^ADDR_W-1.
- R7: Changes to `page_en` or `page_sel` between rewinds have no effect on the sequence of bits.
- R8: After the last bit of the top word of the range, `data_oe` stays low and `casc_n` is low while `cs_n` is low and `rst_oe` is high.
- R9: Once the range is exhausted and while `rst_oe` stays high, `casc_n` equals `cs_n`. `rst_oe` low drives `casc_n` high, and it stays high until the range has been read through again.
- R10: While `ser_en` is low, `data_oe` and `mem_rd_en` are low, `casc_n` is high, and `cs_n`, `rst_oe`, `page_en` and `page_sel` leave the counters and the captured range unchanged.
- R11: After power-on reset and before any rewind, the range is the full space starting at address 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| dclk | input | 1 | Configuration clock; all state changes on its rising edge |
| por_n | input | 1 | Asynchronous power-on reset, active low |
| rst_oe | input | 1 | Low: rewind counters and release data line; high: output enable |
| cs_n | input | 1 | Chip select, active low; high means standby |
| ser_en | input | 1 | High for configuration read-out, low for programming mode |
| page_en | input | 1 | Split the address space into four pages at the next rewind |
| page_sel | input | 2 | Page code captured at rewind (00 lowest quarter) |
| mem_rd_en | output | 1 | Read strobe to the synchronous memory |
| mem_rd_addr | output | ADDR_W | Word address for the read returned next cycle |
| mem_rd_data | input | WORD_W | Word returned one cycle after the address |
| data_out | output | 1 | Serial configuration bit |
| data_oe | output | 1 | Drive enable for the serial data line |
| casc_n | output | 1 | Cascade select to the next device, active low |
| ready | output | 1 | High once the power-on interval has ended |

## Verification
Properties check on every cycle that the counters hold when neither a rewind nor an advance is requested, that a rewind zeroes the bit counter and clears end-of-range, that the word address never leaves the captured range, and that the captured range only moves on a rewind. They also check that the data line is released under a rewind, in programming mode and after end-of-range, and that the ready flag never falls. The order of bits and words, the exact page boundaries, the moment the cascade output falls, and the way it later follows the select can only be shown by the bench. Its scenarios read whole pages and the full space, stall and resume, hop between modes, and change page inputs in the middle of a read.

// File: rtl/cfgrd_pkg.sv
package cfgrd_pkg;
  localparam int PSEL_W = 2;

  typedef enum logic {
    SPAN_FULL  = 1'b0,
    SPAN_PAGED = 1'b1
  } span_e;
endpackage

// File: rtl/cfgrd_por.sv
module cfgrd_por #(
  parameter int POR_CYCLES = 64
) (
  input  logic clk,
  input  logic por_n,
  output logic ready
);
  localparam int CNT_W = $clog2(POR_CYCLES + 1);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      cnt_q <= '0;
      ready <= 1'b0;
    end else if (!ready) begin
      cnt_q <= cnt_q + 1'b1;
      if (cnt_q == CNT_W'(POR_CYCLES - 1)) ready <= 1'b1;
    end
  end

  // R1: once released, ready never drops again
  a_r1_ready_sticky: assert property (@(posedge clk) disable iff (!por_n)
    ready |=> ready);
endmodule

// File: rtl/cfgrd_range.sv
module cfgrd_range
  import cfgrd_pkg::*;
#(
  parameter int ADDR_W = 20
) (
  input  logic              clk,
  input  logic              por_n,
  input  logic              load,
  input  logic              page_en,
  input  logic [PSEL_W-1:0] page_sel,
  output logic [ADDR_W-1:0] base_new,
  output logic [ADDR_W-1:0] base_q,
  output logic [ADDR_W-1:0] top_q
);
  localparam int OFF_W = ADDR_W - PSEL_W;

  span_e             span_new;
  logic [ADDR_W-1:0] top_new;

  always_comb begin
    span_new = page_en ? SPAN_PAGED : SPAN_FULL;
    if (span_new == SPAN_PAGED) begin
      base_new = {page_sel, {OFF_W{1'b0}}};
      top_new  = {page_sel, {OFF_W{1'b1}}};
    end else begin
      base_new = '0;
      top_new  = '1;
    end
  end

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      base_q <= '0;
      top_q  <= '1;
    end else if (load) begin
      base_q <= base_new;
      top_q  <= top_new;
    end
  end

  // R7: captured range only moves on a rewind
  a_r7_range_hold: assert property (@(posedge clk) disable iff (!por_n)
    !load |=> $stable(base_q) && $stable(top_q));
endmodule

// File: rtl/cfgrd_seq.sv
module cfgrd_seq #(
  parameter int ADDR_W = 20,
  parameter int WORD_W = 16
) (
  input  logic                      clk,
  input  logic                      por_n,
  input  logic                      adv,
  input  logic                      load,
  input  logic [ADDR_W-1:0]         base_new,
  input  logic [ADDR_W-1:0]         top_q,
  output logic [ADDR_W-1:0]         addr_q,
  output logic [ADDR_W-1:0]         addr_nxt,
  output logic [$clog2(WORD_W)-1:0] bit_sel,
  output logic                      done
);
  localparam int BIT_W = $clog2(WORD_W);

  logic [BIT_W-1:0] bit_q;
  logic             last_bit;
  logic             at_top;

  assign last_bit = (bit_q == BIT_W'(WORD_W - 1));
  assign at_top   = (addr_q == top_q);
  assign bit_sel  = BIT_W'(WORD_W - 1) - bit_q;

  always_comb begin
    addr_nxt = addr_q;
    if (load)                           addr_nxt = base_new;
    else if (adv && last_bit && !at_top) addr_nxt = addr_q + 1'b1;
  end

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      addr_q <= '0;
      bit_q  <= '0;
      done   <= 1'b0;
    end else begin
      addr_q <= addr_nxt;
      if (load) begin
        bit_q <= '0;
        done  <= 1'b0;
      end else if (adv) begin
        bit_q <= last_bit ? '0 : bit_q + 1'b1;
        if (last_bit && at_top) done <= 1'b1;
      end
    end
  end

  // R3: no request, no movement
  a_r3_counters_hold: assert property (@(posedge clk) disable iff (!por_n)
    !adv && !load |=> $stable(addr_q) && $stable(bit_q));
  // R2: rewind zeroes the bit counter and clears end-of-range
  a_r2_rewind_clears: assert property (@(posedge clk) disable iff (!por_n)
    load |=> bit_q == '0 && !done);
  // R4: bits inside a word step by one
  a_r4_bit_step: assert property (@(posedge clk) disable iff (!por_n)
    adv && !load && !last_bit |=> bit_q == $past(bit_q) + 1'b1);
  // R8: end-of-range holds until a rewind
  a_r8_done_sticky: assert property (@(posedge clk) disable iff (!por_n)
    done && !load |=> done);
endmodule

// File: rtl/cfg_stream_reader.sv
module cfg_stream_reader
  import cfgrd_pkg::*;
#(
  parameter int ADDR_W     = 20,
  parameter int WORD_W     = 16,
  parameter int POR_CYCLES = 64
) (
  input  logic              dclk,
  input  logic              por_n,
  input  logic              rst_oe,
  input  logic              cs_n,
  input  logic              ser_en,
  input  logic              page_en,
  input  logic [PSEL_W-1:0] page_sel,
  output logic              mem_rd_en,
  output logic [ADDR_W-1:0] mem_rd_addr,
  input  logic [WORD_W-1:0] mem_rd_data,
  output logic              data_out,
  output logic              data_oe,
  output logic              casc_n,
  output logic              ready
);
  localparam int BIT_W = $clog2(WORD_W);

  logic              ser_en_q;
  logic              active, load, adv, done;
  logic [ADDR_W-1:0] base_new, base_q, top_q, addr_q, addr_nxt;
  logic [BIT_W-1:0]  bit_sel;

  cfgrd_por #(.POR_CYCLES(POR_CYCLES)) u_por (
    .clk(dclk), .por_n(por_n), .ready(ready)
  );

  always_ff @(posedge dclk or negedge por_n) begin
    if (!por_n) ser_en_q <= 1'b0;
    else        ser_en_q <= ser_en;
  end

  assign active = ready && ser_en && ser_en_q;
  assign load   = active && !rst_oe;
  assign adv    = active && rst_oe && !cs_n && !done;

  cfgrd_range #(.ADDR_W(ADDR_W)) u_range (
    .clk(dclk), .por_n(por_n), .load(load), .page_en(page_en),
    .page_sel(page_sel), .base_new(base_new), .base_q(base_q), .top_q(top_q)
  );

  cfgrd_seq #(.ADDR_W(ADDR_W), .WORD_W(WORD_W)) u_seq (
    .clk(dclk), .por_n(por_n), .adv(adv), .load(load), .base_new(base_new),
    .top_q(top_q), .addr_q(addr_q), .addr_nxt(addr_nxt), .bit_sel(bit_sel),
    .done(done)
  );

  assign mem_rd_en   = ser_en;
  assign mem_rd_addr = addr_nxt;
  assign data_oe     = adv;
  assign data_out    = adv && mem_rd_data[bit_sel];
  assign casc_n      = !(ser_en && done && rst_oe && !cs_n);

  // R5: the word address stays inside the captured range
  a_r5_addr_in_range: assert property (@(posedge dclk) disable iff (!por_n)
    ready |-> addr_q >= base_q && addr_q <= top_q);
  // R2: rewind releases the data line
  a_r2_rewind_tristate: assert property (@(posedge dclk) disable iff (!por_n)
    !rst_oe |-> !data_oe);
  // R10: programming mode is silent
  a_r10_prog_quiet: assert property (@(posedge dclk) disable iff (!por_n)
    !ser_en |-> !data_oe && casc_n && !mem_rd_en);
  // R8: exhausted range never drives the line
  a_r8_handoff: assert property (@(posedge dclk) disable iff (!por_n)
    done |-> !data_oe);
endmodule

// File: tb/cfg_stream_reader_tb.sv
`timescale 1ns/1ps
module cfg_stream_reader_tb;
  localparam int AW  = 6;
  localparam int WW  = 16;
  localparam int POR = 8;
  localparam int QW  = (1 << AW) / 4;

  logic          dclk = 1'b0;
  logic          por_n = 1'b0, rst_oe = 1'b1, cs_n = 1'b1, ser_en = 1'b1;
  logic          page_en = 1'b1;
  logic [1:0]    page_sel = 2'd2;
  logic          mem_rd_en, data_out, data_oe, casc_n, ready;
  logic [AW-1:0] mem_rd_addr;
  logic [WW-1:0] rdata = '0;

  int errors = 0, checks = 0;
  string ph = "R1";
  bit started = 0;
  bit finished = 0;

  // reference state
  int  m_cnt = 0, m_addr = 0, m_bit = 0, m_base = 0, m_top = (1 << AW) - 1;
  bit  m_ready = 0, m_done = 0, m_sq = 0;

  always #2.5 dclk = ~dclk;

  cfg_stream_reader #(.ADDR_W(AW), .WORD_W(WW), .POR_CYCLES(POR)) u_dut (
    .dclk(dclk), .por_n(por_n), .rst_oe(rst_oe), .cs_n(cs_n), .ser_en(ser_en),
    .page_en(page_en), .page_sel(page_sel), .mem_rd_en(mem_rd_en),
    .mem_rd_addr(mem_rd_addr), .mem_rd_data(rdata), .data_out(data_out),
    .data_oe(data_oe), .casc_n(casc_n), .ready(ready)
  );

  function automatic logic [15:0] mw(int a);
    int v = (a * 40503 + 12345) ^ (a << 7);
    return v[15:0];
  endfunction

  always @(posedge dclk) if (mem_rd_en) rdata <= mw(int'(mem_rd_addr));

  always @(posedge dclk) begin
    bit act;
    started = 1;
    if (!por_n) begin
      m_cnt = 0; m_ready = 0; m_addr = 0; m_bit = 0; m_done = 0;
      m_base = 0; m_top = (1 << AW) - 1; m_sq = 0;
    end else begin
      act = m_ready && ser_en && m_sq;
      if (!m_ready) begin
        m_cnt++;
        if (m_cnt == POR) m_ready = 1;
      end else if (act) begin
        if (!rst_oe) begin
          m_base = page_en ? int'(page_sel) * QW : 0;
          m_top  = page_en ? m_base + QW - 1 : (1 << AW) - 1;
          m_addr = m_base; m_bit = 0; m_done = 0;
        end else if (!cs_n && !m_done) begin
          if (m_bit == WW - 1) begin
            m_bit = 0;
            if (m_addr == m_top) m_done = 1; else m_addr++;
          end else m_bit++;
        end
      end
      m_sq = ser_en;
    end
  end

  task automatic chk(string tag, logic act, logic exp, string what);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s (%s) %s act=%0b exp=%0b t=%0t", tag, ph, what, act, exp, $time);
    end
  endtask

  always @(negedge dclk) if (started && !finished) begin
    logic e_oe, e_casc, e_bit;
    logic [15:0] w;
    e_oe   = m_ready && ser_en && m_sq && rst_oe && !cs_n && !m_done;
    e_casc = !(ser_en && m_done && rst_oe && !cs_n);
    w      = mw(m_addr);
    e_bit  = e_oe ? w[WW-1-m_bit] : 1'b0;
    chk("R1", ready, m_ready, "ready");
    chk("R3", data_oe, e_oe, "data_oe");
    chk("R8", casc_n, e_casc, "casc_n");
    chk("R10", mem_rd_en, ser_en, "mem_rd_en");
    chk("R4", data_out, e_bit, "data_out");
  end

  task automatic run(int n);
    repeat (n) begin @(posedge dclk); #1; end
  endtask

  task automatic rewind();
    rst_oe = 1'b0; run(1); rst_oe = 1'b1;
  endtask

  initial begin
    #1_000_000;
    errors++;
    $display("FAIL watchdog expired act=running exp=finished");
    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    run(3); por_n = 1'b1; run(12);
    ph = "R11"; cs_n = 1'b0; run(40);
    ph = "R5";  rewind(); run(300);
    ph = "R8";  run(10);
    ph = "R9";  cs_n = 1'b1; run(3); cs_n = 1'b0; run(3);
    rst_oe = 1'b0; run(2); rst_oe = 1'b1; run(5);
    ph = "R7";  page_sel = 2'd1; page_en = 1'b0; run(20); page_en = 1'b1;
    ph = "R3";  cs_n = 1'b1; run(10); cs_n = 1'b0; run(10);
    ph = "R10"; ser_en = 1'b0; cs_n = 1'b1; page_sel = 2'd3; run(3);
    rst_oe = 1'b0; run(3); rst_oe = 1'b1; cs_n = 1'b0; run(5);
    ser_en = 1'b1; run(20);
    ph = "R5";  page_sel = 2'd3; rewind(); run(270);
    page_sel = 2'd0; rewind(); run(270);
    ph = "R6";  page_en = 1'b0; page_sel = 2'd1; rewind();
    for (int i = 0; i < 1100; i++) begin
      cs_n = (i % 37 == 5); run(1);
    end
    ph = "R9";  cs_n = 1'b0; run(5); cs_n = 1'b1; run(2); cs_n = 1'b0; run(2);
    ph = "R2";  rst_oe = 1'b0; cs_n = 1'b1; run(2); cs_n = 1'b0; run(2);
    rst_oe = 1'b1; run(30);
    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule